// File: doc/BRIEF.md
# Paged Address Translator with Private-Page Protection

This block turns a 16-bit virtual byte address into an 18-bit physical address. The virtual space holds 128 pages of 512 bytes. The upper seven address bits pick a page table entry, and the low nine bits pass through unchanged as the byte offset. Two separate sets of entries are kept, one for Exec mode and one for User mode. A mode register inside the block selects which set serves each access. Entries are written through a fill port by the entry cache. The table is a synchronous-read memory, so it can map onto block RAM.

Each entry holds the following fields:
- a resident flag in bit 15;
- a public flag in bit 14;
- a write-enable flag in bit 13;
- a 9-bit physical page number in bits 8:0.

Every access is graded against the selected entry. The result is either a grant with its physical address, or an abort with a single cause code. Beyond the usual resident and write checks, the block keeps pages of private code and data isolated from public code. It remembers whether the most recent granted instruction fetch came from a private page. Data in private pages is reachable only while that flag is set. Public code may enter a private page only by fetching a word that holds the entry-point instruction 16'o000401.

When translation is switched off, addresses pass straight through with no checks.

Top module: `pgx_translate`

## Requirements
- R1: A granted access with translation on returns rsp_paddr = {entry[8:0], vaddr[8:0]} with rsp_valid high, two clock edges after the edge that samples req_valid.
- R2: mode_we loads mode_in into the mode register; 0 is Exec and 1 is User. A request uses the entry written with tbl_mode equal to the mode register at the edge that samples the request, so the same page number in the two modes can map differently.
- R3: If entry bit 15 (resident) is clear, the access aborts with cause 1 (page missing).
- R4: If the entry's page number is 496 or above, the access aborts with cause 2 (out of range); 495 is still granted.
- R5: If entry bit 14 is clear, the page is private. A read or write to a private page aborts with cause 3 unless the private-fetch flag is set.
- R6: A fetch (req_kind 2) from a private page while the private-fetch flag is clear is granted only when req_iword equals 16'o000401; any other word aborts with cause 3. A fetch from a public page is never refused on privacy grounds.
- R7: A write (req_kind 1) to a page whose entry bit 13 is clear aborts with cause 4. A read (req_kind 0) of that page is granted.
- R8: Only one cause is reported, by fixed priority: cause 1, then 2, then 3, then 4. rsp_grant is high exactly when rsp_cause is 0.
- R9: Every granted fetch sets the private-fetch flag when its page is private and clears it when its page is public. An aborted fetch leaves the flag unchanged.
- R10: With xlat_en low, the access is granted with rsp_paddr = {2'b00, vaddr} and no checks. A fetch made this way clears the private-fetch flag.
- R11: After reset, rsp_valid is low, the mode register is Exec, and the private-fetch flag is clear.
- R12: An aborted access reports rsp_paddr = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xlat_en | input | 1 | Translation on (1) or pass-through (0) |
| mode_we | input | 1 | Load the mode register |
| mode_in | input | 1 | New mode: 0 Exec, 1 User |
| tbl_we | input | 1 | Write one page table entry |
| tbl_mode | input | 1 | Address space of the entry being written |
| tbl_vpn | input | 7 | Virtual page number of the entry being written |
| tbl_data | input | 16 | Entry value |
| req_valid | input | 1 | Access request |
| req_kind | input | 2 | 0 read, 1 write, 2 instruction fetch |
| req_vaddr | input | 16 | Virtual byte address |
| req_iword | input | 16 | Word at the fetch target, used for the entry-point test |
| rsp_valid | output | 1 | Result present |
| rsp_grant | output | 1 | Access allowed |
| rsp_cause | output | 3 | 0 none, 1 missing, 2 range, 3 private, 4 write-protect |
| rsp_paddr | output | 18 | Physical byte address |

## Verification
Every result appears two edges after its request: one edge reads the table, and the next registers the grade. The bench therefore drives a request on a falling edge, holds it for one cycle, and samples the outputs on the second falling edge after that. This places the sample between the result edge and the next rising edge.

Table and mode writes finish at the first edge that samples them, and the bench issues no request in that cycle. The private-fetch flag changes at the same edge as the fetch result. The bench's model therefore updates its own copy of the flag only after it has compared that result, so the following request is graded against the new flag.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_MISSING = 3'd1,
    CAUSE_RANGE   = 3'd2,
    CAUSE_PRIVATE = 3'd3,
    CAUSE_WPROT   = 3'd4
  } cause_e;

  // Entry flag positions (fixed by the entry layout)
  localparam int PTE_RES_BIT = 15;
  localparam int PTE_PUB_BIT = 14;
  localparam int PTE_WEN_BIT = 13;

endpackage

// File: rtl/pgx_pte_store.sv
// Two-space page table: synchronous write, registered read (block RAM shape).
module pgx_pte_store #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pgx_ctx.sv
// Mode register and private-fetch flag.
module pgx_ctx (
  input  logic clk,
  input  logic rst,
  input  logic mode_we,
  input  logic mode_in,
  input  logic fetch_done,
  input  logic fetch_priv,
  output logic mode_q,
  output logic priv_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      priv_q <= 1'b0;
    end else begin
      if (mode_we)    mode_q <= mode_in;
      if (fetch_done) priv_q <= fetch_priv;
    end
  end
endmodule

// File: rtl/pgx_check.sv
// Combinational grading of one access against its entry.
module pgx_check
  import pgx_pkg::*;
#(
  parameter int VA_W       = 16,
  parameter int OFF_W      = 9,
  parameter int PPN_W      = 9,
  parameter int PHYS_PAGES = 496,
  parameter logic [15:0] ENTRY_OP = 16'o000401
) (
  input  logic                    en,
  input  acc_e                    kind,
  input  logic [VA_W-1:0]         vaddr,
  input  logic [15:0]             pte,
  input  logic [15:0]             iword,
  input  logic                    priv_ctx,
  output cause_e                  cause,
  output logic [PPN_W+OFF_W-1:0]  paddr,
  output logic                    page_priv
);
  localparam int PA_W = PPN_W + OFF_W;

  logic [PPN_W-1:0] ppn;
  logic resident, is_public, wr_ok, entry_hit, unused_pte;

  assign ppn        = pte[PPN_W-1:0];
  assign resident   = pte[PTE_RES_BIT];
  assign is_public  = pte[PTE_PUB_BIT];
  assign wr_ok      = pte[PTE_WEN_BIT];
  assign entry_hit  = (kind == ACC_FETCH) && (iword == ENTRY_OP);
  assign unused_pte = ^pte[PTE_WEN_BIT-1:PPN_W];

  always_comb begin
    cause     = CAUSE_NONE;
    paddr     = {ppn, vaddr[OFF_W-1:0]};
    page_priv = 1'b0;
    if (!en) begin
      paddr = PA_W'(vaddr);
    end else begin
      page_priv = ~is_public;
      if (!resident)
        cause = CAUSE_MISSING;
      else if (ppn >= PPN_W'(PHYS_PAGES))
        cause = CAUSE_RANGE;
      else if (!is_public && !priv_ctx && !entry_hit)
        cause = CAUSE_PRIVATE;
      else if (kind == ACC_WRITE && !wr_ok)
        cause = CAUSE_WPROT;
    end
  end
endmodule

// File: rtl/pgx_translate.sv
module pgx_translate
  import pgx_pkg::*;
#(
  parameter int VA_W       = 16,
  parameter int OFF_W      = 9,
  parameter int PPN_W      = 9,
  parameter int PHYS_PAGES = 496,
  parameter logic [15:0] ENTRY_OP = 16'o000401,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PA_W  = PPN_W + OFF_W,
  localparam int TA_W  = VPN_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xlat_en,
  input  logic             mode_we,
  input  logic             mode_in,
  input  logic             tbl_we,
  input  logic             tbl_mode,
  input  logic [VPN_W-1:0] tbl_vpn,
  input  logic [15:0]      tbl_data,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [15:0]      req_iword,
  output logic             rsp_valid,
  output logic             rsp_grant,
  output logic [2:0]       rsp_cause,
  output logic [PA_W-1:0]  rsp_paddr
);
  logic mode_q, priv_q;
  logic [15:0] pte_rd;

  // stage 1: captured request while table is read
  logic            s1_valid, s1_en;
  acc_e            s1_kind;
  logic [VA_W-1:0] s1_vaddr;
  logic [15:0]     s1_iword;

  // stage 2 combinational grade
  cause_e          chk_cause;
  logic [PA_W-1:0] chk_paddr;
  logic            chk_priv, fetch_done;

  cause_e          cause_q;

  pgx_ctx u_ctx (
    .clk        (clk),
    .rst        (rst),
    .mode_we    (mode_we),
    .mode_in    (mode_in),
    .fetch_done (fetch_done),
    .fetch_priv (chk_priv),
    .mode_q     (mode_q),
    .priv_q     (priv_q)
  );

  pgx_pte_store #(.AW(TA_W), .DW(16)) u_store (
    .clk   (clk),
    .we    (tbl_we),
    .waddr ({tbl_mode, tbl_vpn}),
    .wdata (tbl_data),
    .re    (req_valid),
    .raddr ({mode_q, req_vaddr[VA_W-1:OFF_W]}),
    .rdata (pte_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_en    <= 1'b0;
      s1_kind  <= ACC_READ;
      s1_vaddr <= '0;
      s1_iword <= '0;
    end else begin
      s1_valid <= req_valid;
      if (req_valid) begin
        s1_en    <= xlat_en;
        s1_kind  <= acc_e'(req_kind);
        s1_vaddr <= req_vaddr;
        s1_iword <= req_iword;
      end
    end
  end

  pgx_check #(
    .VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W),
    .PHYS_PAGES(PHYS_PAGES), .ENTRY_OP(ENTRY_OP)
  ) u_check (
    .en        (s1_en),
    .kind      (s1_kind),
    .vaddr     (s1_vaddr),
    .pte       (pte_rd),
    .iword     (s1_iword),
    .priv_ctx  (priv_q),
    .cause     (chk_cause),
    .paddr     (chk_paddr),
    .page_priv (chk_priv)
  );

  assign fetch_done = s1_valid && (s1_kind == ACC_FETCH) && (chk_cause == CAUSE_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
      cause_q   <= CAUSE_NONE;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= s1_valid;
      if (s1_valid) begin
        rsp_grant <= (chk_cause == CAUSE_NONE);
        cause_q   <= chk_cause;
        rsp_paddr <= (chk_cause == CAUSE_NONE) ? chk_paddr : '0;
      end
    end
  end

  assign rsp_cause = cause_q;
endmodule

// File: rtl/pgx_translate_chk.sv
module pgx_translate_chk #(
  parameter int VA_W = 16,
  parameter int PA_W = 18,
  parameter int OFF_W = 9,
  parameter int PHYS_PAGES = 496
) (
  input logic            clk,
  input logic            rst,
  input logic            xlat_en,
  input logic            req_valid,
  input logic [VA_W-1:0] req_vaddr,
  input logic            rsp_valid,
  input logic            rsp_grant,
  input logic [2:0]      rsp_cause,
  input logic [PA_W-1:0] rsp_paddr
);
  // R11: no result in the cycle after reset
  a_r11_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> !rsp_valid);

  // R1: result arrives exactly two edges after its request
  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    rsp_valid == $past(req_valid, 2));

  // R1: offset bits carry over on a grant
  a_r1_offset: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_grant) |-> rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0], 2));

  // R8: grant and cause agree, cause within code set
  a_r8_one_cause: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_grant == (rsp_cause == 3'd0)) && (rsp_cause <= 3'd4));

  // R12: aborts carry a zero address
  a_r12_abort_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_grant) |-> rsp_paddr == '0);

  // R4: no granted translated page beyond the last valid one
  a_r4_in_range: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_grant && $past(xlat_en, 2)) |->
      rsp_paddr[PA_W-1:OFF_W] < (PA_W-OFF_W)'(PHYS_PAGES));

  // R10: pass-through grants the untouched address
  a_r10_bypass: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(xlat_en, 2)) |->
      rsp_grant && rsp_paddr == PA_W'($past(req_vaddr, 2)));
endmodule

bind pgx_translate pgx_translate_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .PHYS_PAGES(PHYS_PAGES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .xlat_en   (xlat_en),
  .req_valid (req_valid),
  .req_vaddr (req_vaddr),
  .rsp_valid (rsp_valid),
  .rsp_grant (rsp_grant),
  .rsp_cause (rsp_cause),
  .rsp_paddr (rsp_paddr)
);

// File: tb/pgx_translate_bench.sv
module pgx_translate_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] EOP = 16'o000401;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xlat_en = 1'b1, mode_we = 1'b0, mode_in = 1'b0;
  logic tbl_we = 1'b0, tbl_mode = 1'b0;
  logic [6:0] tbl_vpn = '0;
  logic [15:0] tbl_data = '0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = '0;
  logic [15:0] req_vaddr = '0, req_iword = '0;
  logic rsp_valid, rsp_grant;
  logic [2:0] rsp_cause;
  logic [17:0] rsp_paddr;

  int n_chk = 0, n_bad = 0;
  logic [15:0] ref_tbl [256];
  logic ref_mode = 1'b0, ref_priv = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgx_translate u_pgx_translate (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_pte(input logic m, input logic [6:0] v, input logic [15:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_mode = m; tbl_vpn = v; tbl_data = d;
    @(negedge clk);
    tbl_we = 1'b0;
    ref_tbl[{m, v}] = d;
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    mode_we = 1'b1; mode_in = m;
    @(negedge clk);
    mode_we = 1'b0;
    ref_mode = m;
  endtask

  // expected result from the requirements
  task automatic expect_of(input logic en, input logic [1:0] k, input logic [15:0] va,
                           input logic [15:0] iw, output logic [2:0] c, output logic [17:0] pa,
                           output logic pg_priv);
    logic [15:0] e;
    e = ref_tbl[{ref_mode, va[15:9]}];
    pg_priv = 1'b0;
    if (!en) begin
      c = 0; pa = {2'b00, va};
    end else begin
      pg_priv = !e[14];
      if (!e[15]) c = 1;
      else if (e[8:0] >= 9'd496) c = 2;
      else if (!e[14] && !ref_priv && !(k == 2'd2 && iw == EOP)) c = 3;
      else if (k == 2'd1 && !e[13]) c = 4;
      else c = 0;
      pa = (c == 0) ? {e[8:0], va[8:0]} : 18'd0;
    end
  endtask

  task automatic access(input string tag, input logic en, input logic [1:0] k,
                        input logic [15:0] va, input logic [15:0] iw);
    logic [2:0] c; logic [17:0] pa; logic pp;
    expect_of(en, k, va, iw, c, pa, pp);
    @(negedge clk);
    xlat_en = en; req_valid = 1'b1; req_kind = k; req_vaddr = va; req_iword = iw;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check({tag, " valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " cause"}, 32'(rsp_cause), 32'(c));
    check({tag, " grant"}, 32'(rsp_grant), 32'(c == 0));
    check({tag, " paddr"}, 32'(rsp_paddr), 32'(pa));
    if (k == 2'd2 && c == 0) ref_priv = pp;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 rsp_valid after reset", 32'(rsp_valid), 32'd0);

    for (int i = 0; i < 256; i++) put_pte(i[7], i[6:0], 16'hE000 | 16'(i));

    // R11: mode Exec, flag clear: Exec entry used, private page refused
    put_pte(1'b0, 7'd5, 16'h8000 | 16'd7);        // resident, private
    access("R11 private data after reset", 1, 0, 16'h0A10, 0);
    // R1 basic read and write
    put_pte(1'b0, 7'd3, 16'hE000 | 16'd300);
    access("R1 read", 1, 0, 16'h0612, 0);
    access("R1 write", 1, 1, 16'h07FF, 0);
    // R2 mode selects space
    put_pte(1'b1, 7'd3, 16'hE000 | 16'd17);
    set_mode(1'b1);
    access("R2 user space", 1, 0, 16'h0612, 0);
    set_mode(1'b0);
    access("R2 exec space", 1, 0, 16'h0612, 0);
    // R3 missing
    put_pte(1'b0, 7'd9, 16'h6000 | 16'd4);
    access("R3 not resident", 1, 0, 16'h1200, 0);
    // R4 range boundary
    put_pte(1'b0, 7'd10, 16'hE000 | 16'd495);
    access("R4 page 495", 1, 0, 16'h1401, 0);
    put_pte(1'b0, 7'd11, 16'hE000 | 16'd496);
    access("R4 page 496", 1, 0, 16'h1601, 0);
    // R7 write protect
    put_pte(1'b0, 7'd12, 16'hC000 | 16'd40);
    access("R7 write refused", 1, 1, 16'h1802, 0);
    access("R7 read allowed", 1, 0, 16'h1802, 0);
    // R8 priority: missing beats range, private, write
    put_pte(1'b0, 7'd13, 16'h01F8);
    access("R8 missing first", 1, 1, 16'h1A00, 0);
    put_pte(1'b0, 7'd14, 16'h81F8);
    access("R8 range before private", 1, 1, 16'h1C00, 0);
    put_pte(1'b0, 7'd15, 16'h8000 | 16'd50);
    access("R8 private before wprot", 1, 1, 16'h1E00, 0);
    // R6 entry point
    access("R6 wrong entry word", 1, 2, 16'h0A00, 16'o000402);
    access("R9 flag still public", 1, 0, 16'h0A04, 0);
    access("R6 entry point fetch", 1, 2, 16'h0A00, EOP);
    // R5 private data now allowed, R9 flag set
    access("R5 private data allowed", 1, 0, 16'h0A20, 0);
    access("R9 private sequential fetch", 1, 2, 16'h0A02, 16'h1234);
    access("R9 aborted fetch", 1, 2, 16'h1200, 0);
    access("R9 flag kept after abort", 1, 0, 16'h0A22, 0);
    access("R9 public fetch", 1, 2, 16'h0612, 0);
    access("R5 private refused again", 1, 0, 16'h0A22, 0);
    // R10 bypass, fetch clears flag
    access("R6 enter again", 1, 2, 16'h0A00, EOP);
    access("R10 bypass fetch", 0, 2, 16'hFFFE, 0);
    access("R10 flag cleared", 1, 0, 16'h0A24, 0);
    access("R10 bypass write", 0, 1, 16'h1200, 0);
    // R12 covered by every abort above; random mix
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] d, va, iw;
      logic [1:0] k;
      if (i % 50 == 0) begin
        for (int j = 0; j < 8; j++) begin
          d = 16'($urandom);
          if ($urandom % 6 != 0) d[15] = 1'b1;
          if ($urandom % 3 != 0) d[8:0] = 9'($urandom % 496);
          put_pte(1'($urandom), 7'($urandom % 16), d);
        end
        if ($urandom % 2 == 0) set_mode(1'($urandom));
      end
      va = {4'd0, 12'($urandom)};
      k = 2'($urandom % 3);
      iw = ($urandom % 3 == 0) ? EOP : 16'($urandom);
      access("R12 random mix", ($urandom % 10) != 0, k, va, iw);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule